// File: doc/BRIEF.md
# Address-Range Transaction Tagger

This block sits in the write-address and read-address channels of an AXI-style bus. It compares every request address against a table of partitions. Each partition has a 2-bit match mode, a configured address word and a tag value. When a request falls inside an enabled partition, the tag of the winning partition is written into a fixed slice of the request's user field. The address, valid, ready and every user bit outside the slice pass through unchanged.

The table arrives on flat configuration buses driven by a register file outside this block. Both address channels look up the same table, and each does its own lookup at the same time. The work is purely combinational, so it adds no latency and no storage to the request path. Data and response channels do not go through this block.

Top module: `addr_tagger`

## Requirements
- R1: A partition whose mode field is 2'b00 (off) never matches any address.
- R2: In mode 2'b10 (4-byte region) a partition matches exactly when request address bits [ADDR_W-1:2] equal its configured word. The configured word holds a byte address shifted right by two.
- R3: In mode 2'b01 (top of range) partition i matches when word(i-1) <= addr[ADDR_W-1:2] < word(i), with unsigned comparison. For partition 0 the lower bound is zero. The lower bound is taken from the neighbour's word whatever that neighbour's mode is.
- R4: In mode 2'b11 (power-of-two region) a configured word with k trailing ones selects an aligned region of 2^(k+3) bytes. The shifted address bits above bit k are compared exactly. A word of all ones matches every address.
- R5: When several partitions match, the one with the lowest index supplies the tag.
- R6: When no partition matches, user bits [TAG_MSB:TAG_LSB] are driven to zero.
- R7: User bits outside [TAG_MSB:TAG_LSB] and the address leave unchanged, in the same cycle.
- R8: Valid passes from slave side to master side, and ready passes from master side to slave side, with no added cycle.
- R9: The write and read channels are tagged from the same partition table, each from its own address at the same time.
- R10: The configuration is packed flat. Partition i uses word bits [i*(ADDR_W-2) +: ADDR_W-2], mode bits [2i +: 2] and tag bits [i*TAG_W +: TAG_W], where TAG_W = TAG_MSB-TAG_LSB+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_word_i | input | NUM_PART*(ADDR_W-2) | Partition address words (byte address >> 2) |
| cfg_mode_i | input | 2*NUM_PART | Partition match modes |
| cfg_tag_i | input | NUM_PART*TAG_W | Partition tag values |
| s_aw_addr_i | input | ADDR_W | Write request address, slave side |
| s_aw_user_i | input | USER_W | Write request user field, slave side |
| s_aw_valid_i | input | 1 | Write request valid, slave side |
| s_aw_ready_o | output | 1 | Write request ready, slave side |
| m_aw_addr_o | output | ADDR_W | Write request address, master side |
| m_aw_user_o | output | USER_W | Tagged write user field, master side |
| m_aw_valid_o | output | 1 | Write request valid, master side |
| m_aw_ready_i | input | 1 | Write request ready, master side |
| s_ar_addr_i | input | ADDR_W | Read request address, slave side |
| s_ar_user_i | input | USER_W | Read request user field, slave side |
| s_ar_valid_i | input | 1 | Read request valid, slave side |
| s_ar_ready_o | output | 1 | Read request ready, slave side |
| m_ar_addr_o | output | ADDR_W | Read request address, master side |
| m_ar_user_o | output | USER_W | Tagged read user field, master side |
| m_ar_valid_o | output | 1 | Read request valid, master side |
| m_ar_ready_i | input | 1 | Read request ready, master side |

## Verification
The assertions check four things whenever the logic settles. A partition that is switched off reports no hit. At most one partition wins the priority choice. A lookup with no winner yields a zero tag. The user bits outside the tag slice match the incoming ones. The bench's scenarios are the only way to show the range arithmetic: the 4-byte, top-of-range and power-of-two region edges, priority between overlapping partitions, and both channels looking up one table with different addresses. It does this with directed edge addresses and random tables compared against a behavioural model.

// File: rtl/addr_tag_pkg.sv
package addr_tag_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_RANGE = 2'b01,
    MODE_WORD  = 2'b10,
    MODE_POW2  = 2'b11
  } match_mode_e;
endpackage

// File: rtl/addr_tag_region_match.sv
module addr_tag_region_match
  import addr_tag_pkg::*;
#(
  parameter int unsigned CW = 30
) (
  input  match_mode_e     mode_i,
  input  logic [CW-1:0]   word_i,
  input  logic [CW-1:0]   prev_i,
  input  logic [CW-1:0]   addr_word_i,
  output logic            hit_o
);
  logic [CW-1:0] pow2_ign;

  always_comb begin
    // trailing ones of the word plus the next bit are don't-care positions
    pow2_ign = word_i ^ (word_i + {{(CW-1){1'b0}}, 1'b1});
    unique case (mode_i)
      MODE_OFF:   hit_o = 1'b0;
      MODE_RANGE: hit_o = (addr_word_i >= prev_i) && (addr_word_i < word_i);
      MODE_WORD:  hit_o = (addr_word_i == word_i);
      MODE_POW2:  hit_o = (((addr_word_i ^ word_i) & ~pow2_ign) == '0);
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/addr_tag_lookup.sv
module addr_tag_lookup
  import addr_tag_pkg::*;
#(
  parameter int unsigned NUM_PART = 4,
  parameter int unsigned CW       = 30,
  parameter int unsigned TAG_W    = 3
) (
  input  logic [NUM_PART*CW-1:0]    cfg_word_i,
  input  logic [2*NUM_PART-1:0]     cfg_mode_i,
  input  logic [NUM_PART*TAG_W-1:0] cfg_tag_i,
  input  logic [CW-1:0]             addr_word_i,
  output logic                      hit_o,
  output logic [TAG_W-1:0]          tag_o
);
  logic [NUM_PART-1:0] part_hit;
  logic [NUM_PART-1:0] grant;

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    logic [CW-1:0] lower;
    if (p == 0) begin : g_first
      assign lower = '0;
    end else begin : g_rest
      assign lower = cfg_word_i[(p-1)*CW +: CW];
    end
    addr_tag_region_match #(.CW(CW)) match_i (
      .mode_i      (match_mode_e'(cfg_mode_i[2*p +: 2])),
      .word_i      (cfg_word_i[p*CW +: CW]),
      .prev_i      (lower),
      .addr_word_i (addr_word_i),
      .hit_o       (part_hit[p])
    );
  end

  // lowest index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    tag_o = '0;
    for (int p = 0; p < NUM_PART; p++) begin
      if (part_hit[p] && !taken) begin
        grant[p] = 1'b1;
        tag_o    = cfg_tag_i[p*TAG_W +: TAG_W];
        taken    = 1'b1;
      end
    end
    hit_o = taken;
  end

  always_comb begin
    for (int p = 0; p < NUM_PART; p++) begin
      // R1
      off_no_hit_chk: assert (!(cfg_mode_i[2*p +: 2] == 2'b00 && part_hit[p]));
    end
    // R5
    single_grant_chk: assert ($onehot0(grant));
    // R6
    miss_zero_tag_chk: assert (hit_o || (tag_o == '0));
  end
endmodule

// File: rtl/addr_tag_inject.sv
module addr_tag_inject #(
  parameter int unsigned USER_W  = 8,
  parameter int unsigned TAG_LSB = 2,
  parameter int unsigned TAG_MSB = 4,
  localparam int unsigned TAG_W  = TAG_MSB - TAG_LSB + 1
) (
  input  logic [USER_W-1:0] user_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic [USER_W-1:0] user_o
);
  always_comb begin
    user_o                  = user_i;
    user_o[TAG_MSB:TAG_LSB] = tag_i;
  end

  always_comb begin
    for (int b = 0; b < USER_W; b++) begin
      if (b < TAG_LSB || b > TAG_MSB) begin
        // R7
        keep_user_chk: assert (user_o[b] == user_i[b]);
      end
    end
  end
endmodule

// File: rtl/addr_tagger.sv
module addr_tagger #(
  parameter int unsigned NUM_PART = 4,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned USER_W   = 8,
  parameter int unsigned TAG_LSB  = 2,
  parameter int unsigned TAG_MSB  = 4,
  localparam int unsigned CW      = ADDR_W - 2,
  localparam int unsigned TAG_W   = TAG_MSB - TAG_LSB + 1
) (
  input  logic [NUM_PART*CW-1:0]    cfg_word_i,
  input  logic [2*NUM_PART-1:0]     cfg_mode_i,
  input  logic [NUM_PART*TAG_W-1:0] cfg_tag_i,
  input  logic [ADDR_W-1:0]         s_aw_addr_i,
  input  logic [USER_W-1:0]         s_aw_user_i,
  input  logic                      s_aw_valid_i,
  output logic                      s_aw_ready_o,
  output logic [ADDR_W-1:0]         m_aw_addr_o,
  output logic [USER_W-1:0]         m_aw_user_o,
  output logic                      m_aw_valid_o,
  input  logic                      m_aw_ready_i,
  input  logic [ADDR_W-1:0]         s_ar_addr_i,
  input  logic [USER_W-1:0]         s_ar_user_i,
  input  logic                      s_ar_valid_i,
  output logic                      s_ar_ready_o,
  output logic [ADDR_W-1:0]         m_ar_addr_o,
  output logic [USER_W-1:0]         m_ar_user_o,
  output logic                      m_ar_valid_o,
  input  logic                      m_ar_ready_i
);
  logic [1:0]            ch_hit;
  logic [1:0][TAG_W-1:0] ch_tag;
  logic [1:0][CW-1:0]    ch_word;
  logic [1:0][USER_W-1:0] ch_user_in;
  logic [1:0][USER_W-1:0] ch_user_out;

  assign ch_word[0]    = s_aw_addr_i[ADDR_W-1:2];
  assign ch_word[1]    = s_ar_addr_i[ADDR_W-1:2];
  assign ch_user_in[0] = s_aw_user_i;
  assign ch_user_in[1] = s_ar_user_i;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    addr_tag_lookup #(.NUM_PART(NUM_PART), .CW(CW), .TAG_W(TAG_W)) lookup_i (
      .cfg_word_i  (cfg_word_i),
      .cfg_mode_i  (cfg_mode_i),
      .cfg_tag_i   (cfg_tag_i),
      .addr_word_i (ch_word[c]),
      .hit_o       (ch_hit[c]),
      .tag_o       (ch_tag[c])
    );
    addr_tag_inject #(.USER_W(USER_W), .TAG_LSB(TAG_LSB), .TAG_MSB(TAG_MSB)) inject_i (
      .user_i (ch_user_in[c]),
      .tag_i  (ch_tag[c]),
      .user_o (ch_user_out[c])
    );
  end

  assign m_aw_addr_o  = s_aw_addr_i;
  assign m_aw_user_o  = ch_user_out[0];
  assign m_aw_valid_o = s_aw_valid_i;
  assign s_aw_ready_o = m_aw_ready_i;
  assign m_ar_addr_o  = s_ar_addr_i;
  assign m_ar_user_o  = ch_user_out[1];
  assign m_ar_valid_o = s_ar_valid_i;
  assign s_ar_ready_o = m_ar_ready_i;
endmodule

// File: tb/addr_tagger_tb_top.sv
module addr_tagger_tb_top;
  localparam int NP = 4;
  localparam int AW = 32;
  localparam int UW = 8;
  localparam int LSB = 2;
  localparam int MSB = 4;
  localparam int CW = AW - 2;
  localparam int TW = MSB - LSB + 1;

  logic clk;
  logic rst_n;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  logic [CW-1:0] word_tab [NP];
  logic [1:0]    mode_tab [NP];
  logic [TW-1:0] tag_tab  [NP];

  logic [NP*CW-1:0] cfg_word;
  logic [2*NP-1:0]  cfg_mode;
  logic [NP*TW-1:0] cfg_tag;

  logic [AW-1:0] aw_addr, ar_addr, m_aw_addr, m_ar_addr;
  logic [UW-1:0] aw_user, ar_user, m_aw_user, m_ar_user;
  logic aw_valid, ar_valid, m_aw_valid, m_ar_valid;
  logic aw_ready_m, ar_ready_m, s_aw_ready, s_ar_ready;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      cfg_word[p*CW +: CW] = word_tab[p];
      cfg_mode[2*p +: 2]   = mode_tab[p];
      cfg_tag[p*TW +: TW]  = tag_tab[p];
    end
  end

  addr_tagger #(.NUM_PART(NP), .ADDR_W(AW), .USER_W(UW), .TAG_LSB(LSB), .TAG_MSB(MSB)) dut_i (
    .cfg_word_i(cfg_word), .cfg_mode_i(cfg_mode), .cfg_tag_i(cfg_tag),
    .s_aw_addr_i(aw_addr), .s_aw_user_i(aw_user), .s_aw_valid_i(aw_valid),
    .s_aw_ready_o(s_aw_ready), .m_aw_addr_o(m_aw_addr), .m_aw_user_o(m_aw_user),
    .m_aw_valid_o(m_aw_valid), .m_aw_ready_i(aw_ready_m),
    .s_ar_addr_i(ar_addr), .s_ar_user_i(ar_user), .s_ar_valid_i(ar_valid),
    .s_ar_ready_o(s_ar_ready), .m_ar_addr_o(m_ar_addr), .m_ar_user_o(m_ar_user),
    .m_ar_valid_o(m_ar_valid), .m_ar_ready_i(ar_ready_m)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference: expected tag for a byte address
  function automatic logic [TW-1:0] ref_tag(logic [AW-1:0] a);
    longint aw = longint'(a) >> 2;
    for (int p = 0; p < NP; p++) begin
      longint w  = longint'(word_tab[p]);
      longint lo = (p == 0) ? 0 : longint'(word_tab[p-1]);
      bit hit = 0;
      int k = 0;
      case (mode_tab[p])
        2'b01: hit = (lo <= aw) && (aw < w);
        2'b10: hit = (aw == w);
        2'b11: begin
          while (k < CW && word_tab[p][k]) k++;
          hit = ((aw >> (k + 1)) == (w >> (k + 1)));
        end
        default: hit = 0;
      endcase
      if (hit) return tag_tab[p];
    end
    return '0;
  endfunction

  function automatic logic [UW-1:0] ref_user(logic [AW-1:0] a, logic [UW-1:0] u);
    logic [UW-1:0] r = u;
    r[MSB:LSB] = ref_tag(a);
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [AW-1:0] wa, logic [AW-1:0] ra);
    @(posedge clk);
    aw_addr = wa; ar_addr = ra;
    aw_user = UW'($urandom); ar_user = UW'($urandom);
    aw_valid = 1'($urandom); ar_valid = 1'($urandom);
    aw_ready_m = 1'($urandom); ar_ready_m = 1'($urandom);
    @(negedge clk);
  endtask

  task automatic cmp_all(string req);
    chk({req, " aw user"}, 64'(m_aw_user), 64'(ref_user(aw_addr, aw_user)));
    chk({req, " ar user"}, 64'(m_ar_user), 64'(ref_user(ar_addr, ar_user)));
    chk("R7 addr", {m_aw_addr, m_ar_addr}, {aw_addr, ar_addr});
    chk("R8 hs", 64'({m_aw_valid, s_aw_ready, m_ar_valid, s_ar_ready}),
        64'({aw_valid, aw_ready_m, ar_valid, ar_ready_m}));
  endtask

  task automatic tag_is(string req, logic [AW-1:0] a, logic [TW-1:0] exp);
    drive(a, a);
    chk(req, 64'(m_aw_user[MSB:LSB]), 64'(exp));
    chk(req, 64'(m_ar_user[MSB:LSB]), 64'(exp));
    cmp_all(req);
  endtask

  task automatic clear_tab();
    for (int p = 0; p < NP; p++) begin
      word_tab[p] = '0; mode_tab[p] = 2'b00; tag_tab[p] = TW'(p + 1);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear_tab();
    aw_addr = '0; ar_addr = '0; aw_user = '0; ar_user = '0;
    aw_valid = 0; ar_valid = 0; aw_ready_m = 0; ar_ready_m = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: all off, no tag
    chk("R6 reset aw", 64'(m_aw_user), 64'(aw_user));
    chk("R6 reset ar", 64'(m_ar_user), 64'(ar_user));

    // R1: off partitions with matching words never hit
    word_tab[0] = 30'h100; word_tab[1] = 30'h3FFF_FFFF;
    tag_is("R1 off", 32'h400, 3'd0);
    tag_is("R1 off", 32'h0, 3'd0);

    // R2: 4-byte region
    clear_tab(); mode_tab[0] = 2'b10; word_tab[0] = 30'h100;
    tag_is("R2 base", 32'h400, 3'd1);
    tag_is("R2 last byte", 32'h403, 3'd1);
    tag_is("R2 next word", 32'h404, 3'd0);
    tag_is("R2 below", 32'h3FC, 3'd0);

    // R3: top of range, partition 0 from zero, partition 1 from word0
    clear_tab(); mode_tab[0] = 2'b01; word_tab[0] = 30'h10;
    mode_tab[1] = 2'b01; word_tab[1] = 30'h20;
    tag_is("R3 zero", 32'h0, 3'd1);
    tag_is("R3 top-1", 32'h3C, 3'd1);
    tag_is("R3 boundary", 32'h40, 3'd2);
    tag_is("R3 top1-1", 32'h7F, 3'd2);
    tag_is("R3 top1", 32'h80, 3'd0);
    mode_tab[0] = 2'b00;
    tag_is("R3 lower from off neighbour", 32'h3C, 3'd0);

    // R4: power-of-two, word 0x103 (k=2) -> 32 bytes at 0x400
    clear_tab(); mode_tab[0] = 2'b11; word_tab[0] = 30'h103;
    tag_is("R4 base", 32'h400, 3'd1);
    tag_is("R4 top", 32'h41F, 3'd1);
    tag_is("R4 above", 32'h420, 3'd0);
    tag_is("R4 below", 32'h3FC, 3'd0);
    word_tab[0] = 30'h100;
    tag_is("R4 k0 8B", 32'h407, 3'd1);
    tag_is("R4 k0 above", 32'h408, 3'd0);
    word_tab[0] = 30'h3FFF_FFFF;
    tag_is("R4 all ones", 32'hDEAD_BEEF, 3'd1);

    // R5: overlap, lowest index wins
    clear_tab(); mode_tab[2] = 2'b10; word_tab[2] = 30'h100;
    mode_tab[3] = 2'b11; word_tab[3] = 30'h3FFF_FFFF;
    tag_is("R5 low index", 32'h400, 3'd3);
    tag_is("R5 fallthrough", 32'h800, 3'd4);

    // R9: different addresses on the two channels
    clear_tab(); mode_tab[0] = 2'b10; word_tab[0] = 30'h100;
    mode_tab[1] = 2'b10; word_tab[1] = 30'h200;
    drive(32'h400, 32'h800);
    chk("R9 aw", 64'(m_aw_user[MSB:LSB]), 64'd1);
    chk("R9 ar", 64'(m_ar_user[MSB:LSB]), 64'd2);
    cmp_all("R9");

    // random tables and near-boundary addresses, R10 packing via model
    for (int it = 0; it < 3000; it++) begin
      if (it % 50 == 0) begin
        for (int p = 0; p < NP; p++) begin
          mode_tab[p] = 2'($urandom);
          word_tab[p] = ($urandom % 2) ? CW'($urandom) : CW'(($urandom % 64) * 16 + (p * 256));
          tag_tab[p]  = TW'($urandom);
        end
      end
      begin
        logic [AW-1:0] a[2];
        for (int c = 0; c < 2; c++) begin
          int p = int'($urandom % NP);
          logic [CW-1:0] w = word_tab[p] + CW'(int'($urandom % 5) - 2);
          if ($urandom % 4 == 0) w = w ^ CW'($urandom % 64);
          a[c] = {w, 2'($urandom)};
        end
        drive(a[0], a[1]);
        cmp_all("R10 random R2 R3 R4 R5 R7");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule